// File: doc/BRIEF.md
# Dual-Mode Synthesizer Control Port

This block is the write-only control port of a frequency synthesizer. Two serial transports share the same pair of pins: a 3-wire shift port (shift clock, data and a framing enable) and an I2C slave that only accepts writes. A mode pin picks which one listens, and the other one is held idle. Every transfer carries a 24-bit control word. The last bit of that word steers it into one of two register banks. One bank holds the main divider and two test bits. The other holds the reference divider, the phase detector polarity, the unlock threshold and stretch selects, and three band-switch port bits.

All pins are brought into the system clock domain by two-flop synchronizers and processed on detected edges, so the block runs on one clock. A bank only changes once a complete word has arrived. Divider values below the legal floor are raised to that floor when they load, and a flag reports it. The dividers, the phase detector and the charge pump sit outside this block and consume its register outputs.

Top module: `synth_ctl_if`

## Requirements
- R1: `bus_sel` low selects the 3-wire port and `bus_sel` high selects I2C. Traffic in the format of the unselected transport changes no register and draws no acknowledge.
- R2: A word is 24 bits, sent MSB first, so bit 23 comes first and bit 0 comes last. Bit 0 is the bank-select bit. Main bank: bits 17:1 are the main divider (bit 1 is its LSB) and bits 19:18 are `test_bits`. Reference bank: bits 12:1 are the reference divider (bit 1 is its LSB), bit 13 is `pd_pol`, bit 14 is `unlock_thr`, bits 16:15 are `unlock_ext`, and bits 19:17 are the port bits for `band_n[2:0]`. Bits 23:20 are ignored.
- R3: In 3-wire mode, data is sampled on each rising `sclk_i` while `ce_i` is low. On a rising `ce_i`, the word is applied only if exactly 24 bits were shifted. Shorter or longer frames are discarded.
- R4: A word with bit 0 = 1 loads only the main bank. A word with bit 0 = 0 loads only the reference bank. The other bank keeps its values.
- R5: I2C address byte: bits 7:2 must equal `DEV_ADDR` (default 6'b110001), bit 1 must equal the level on `ce_i`, and bit 0 must be 0 (write). A matching address is acknowledged by pulling the data line low for the ninth clock. A read request or a mismatch is not acknowledged, and the rest of that transfer is ignored.
- R6: In I2C mode, the first three data bytes are acknowledged, and the first byte carries word bits 23:16. The word is applied on the stop condition only if exactly three data bytes arrived. A fourth byte is not acknowledged and voids the transfer, and so does a stop after fewer than three bytes.
- R7: Port bit 0 drives its `band_n` output high and port bit 1 drives it low.
- R8: A main divider value below 4032 loads as 4032, and a reference divider value below 20 loads as 20. `clamp_flag` is 1 after a write that was raised this way and 0 after a write that was not.
- R9: `rst` sets the main divider to 4032, the reference divider to 20, all other fields and `clamp_flag` to 0, and every `band_n` output high. While `i2c_rst_n` is low the I2C slave returns to idle, and it drops any partial transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Transport select: 0 = 3-wire, 1 = I2C |
| i2c_rst_n | input | 1 | Active-low reset of the I2C slave only |
| sclk_i | input | 1 | Shift clock (3-wire) or SCL (I2C) |
| sdat_i | input | 1 | Serial data (3-wire) or sensed SDA line (I2C) |
| ce_i | input | 1 | Frame enable (3-wire) or address-select level (I2C) |
| sdat_oe | output | 1 | Pull SDA low to acknowledge |
| main_div | output | 17 | Main divider value |
| test_bits | output | 2 | Test field of the main bank |
| ref_div | output | 12 | Reference divider value |
| pd_pol | output | 1 | Phase detector polarity |
| unlock_thr | output | 1 | Unlock threshold select |
| unlock_ext | output | 2 | Unlock indication stretch select |
| band_n | output | 3 | Band-switch outputs, active low |
| clamp_flag | output | 1 | Last write was raised to the divider floor |

## Verification
The load of a word and the floor clamp happen in the same clock cycle. In that cycle the divider takes the floor value and `clamp_flag` takes its new state together. The bench provokes this with main divider writes of 4031, 4032 and 0, and reference writes of 19 and 20. The scoreboard then checks the divider, the flag and the untouched other bank as one snapshot, taken after the load and before the next transfer starts.

// File: rtl/synth_ctl_pkg.sv
package synth_ctl_pkg;
  localparam int WORD_W    = 24;
  localparam int MAIN_W    = 17;
  localparam int REF_W     = 12;
  localparam int TEST_W    = 2;
  localparam int EXT_W     = 2;
  localparam int BAND_N    = 3;
  localparam int DEVA_W    = 6;
  localparam int MAIN_MIN  = 4032;
  localparam int REF_MIN   = 20;
  localparam int SEL_BIT   = 0;
  localparam int DIV_LSB   = 1;
  localparam int POL_BIT   = DIV_LSB + REF_W;
  localparam int THR_BIT   = POL_BIT + 1;
  localparam int EXT_LSB   = THR_BIT + 1;
  localparam int PORT_LSB  = EXT_LSB + EXT_W;
  localparam int TEST_LSB  = DIV_LSB + MAIN_W;
  localparam int USED_W    = PORT_LSB + BAND_N;
  localparam int NBYTES    = WORD_W / 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_SKIP = 2'd3
  } i2c_st_t;
endpackage

// File: rtl/synth_pin_sync.sv
module synth_pin_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '1;
      q    <= '1;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/synth_tw_rx.sv
module synth_tw_rx import synth_ctl_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              sclk,
  input  logic              sdat,
  input  logic              cen,
  output logic              word_v,
  output logic [WORD_W-1:0] word
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] OVER = CNT_W'(WORD_W + 1);

  logic              sclk_q, cen_q;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      sclk_q <= sclk;
      cen_q  <= cen;
      cnt    <= '0;
      word_v <= 1'b0;
    end else begin
      sclk_q <= sclk;
      cen_q  <= cen;
      word_v <= 1'b0;
      if (cen && !cen_q) begin
        if (cnt == FULL) begin
          word   <= sr;
          word_v <= 1'b1;
        end
        cnt <= '0;
      end else if (!cen && sclk && !sclk_q) begin
        sr <= {sr[WORD_W-2:0], sdat};
        if (cnt != OVER) cnt <= cnt + 1'b1;
      end
    end
  end

  p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    word_v |=> !word_v);
  p_idle_when_off_r1: assert property (@(posedge clk) disable iff (rst)
    !en |=> !word_v);
endmodule

// File: rtl/synth_i2c_wr.sv
module synth_i2c_wr import synth_ctl_pkg::*; #(
  parameter logic [DEVA_W-1:0] DEV_ADDR = 6'b110001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              scl,
  input  logic              sda,
  input  logic              ce,
  output logic              sda_oe,
  output logic              word_v,
  output logic [WORD_W-1:0] word
);
  localparam int BC_W = $clog2(NBYTES + 1);
  localparam logic [BC_W-1:0] NB = BC_W'(NBYTES);

  i2c_st_t           state;
  logic              scl_q, sda_q, ack_ok;
  logic [3:0]        bitcnt;
  logic [BC_W-1:0]   nbytes;
  logic [7:0]        sr;
  logic [WORD_W-1:0] wsr;
  logic              scl_rise, scl_fall, start_c, stop_c;
  logic [7:0]        byte_in;

  assign scl_rise = scl && !scl_q;
  assign scl_fall = !scl && scl_q;
  assign start_c  = scl && scl_q && sda_q && !sda;
  assign stop_c   = scl && scl_q && !sda_q && sda;
  assign byte_in  = {sr[6:0], sda};

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      scl_q  <= scl;
      sda_q  <= sda;
      state  <= ST_IDLE;
      bitcnt <= '0;
      nbytes <= '0;
      ack_ok <= 1'b0;
      sda_oe <= 1'b0;
      word_v <= 1'b0;
    end else begin
      scl_q  <= scl;
      sda_q  <= sda;
      word_v <= 1'b0;
      if (start_c) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        nbytes <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        if (state == ST_DATA && nbytes == NB && bitcnt <= 4'd1) begin
          word   <= wsr;
          word_v <= 1'b1;
        end
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (scl_rise) begin
          if (bitcnt == 4'd8) begin
            bitcnt <= '0;
            case (state)
              ST_ADDR: state <= ack_ok ? ST_DATA : ST_SKIP;
              ST_DATA: if (ack_ok) nbytes <= nbytes + 1'b1;
                       else        state  <= ST_SKIP;
              default: ;
            endcase
          end else begin
            bitcnt <= bitcnt + 1'b1;
            sr     <= byte_in;
            if (state == ST_DATA && nbytes != NB)
              wsr <= {wsr[WORD_W-2:0], sda};
            if (bitcnt == 4'd7)
              ack_ok <= (state == ST_ADDR) ?
                        (byte_in[7:2] == DEV_ADDR && byte_in[1] == ce && !byte_in[0]) :
                        (state == ST_DATA && nbytes != NB);
          end
        end
        if (scl_fall) sda_oe <= (bitcnt == 4'd8) && ack_ok;
      end
    end
  end

  p_ack_while_low_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl);
  p_off_no_ack_r1: assert property (@(posedge clk) disable iff (rst)
    !en |=> !sda_oe);
  p_word_from_data_r6: assert property (@(posedge clk) disable iff (rst)
    word_v |-> $past(state) == ST_DATA);
endmodule

// File: rtl/synth_ctl_regs.sv
module synth_ctl_regs import synth_ctl_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output logic [MAIN_W-1:0] main_div,
  output logic [TEST_W-1:0] test_bits,
  output logic [REF_W-1:0]  ref_div,
  output logic              pd_pol,
  output logic              unlock_thr,
  output logic [EXT_W-1:0]  unlock_ext,
  output logic [BAND_N-1:0] band_n,
  output logic              clamp_flag
);
  localparam logic [MAIN_W-1:0] MAIN_FLOOR = MAIN_W'(MAIN_MIN);
  localparam logic [REF_W-1:0]  REF_FLOOR  = REF_W'(REF_MIN);

  logic [MAIN_W-1:0] main_raw;
  logic [REF_W-1:0]  ref_raw;
  logic              main_lo, ref_lo;
  logic              unused_dc;

  assign main_raw  = word[DIV_LSB +: MAIN_W];
  assign ref_raw   = word[DIV_LSB +: REF_W];
  assign main_lo   = main_raw < MAIN_FLOOR;
  assign ref_lo    = ref_raw < REF_FLOOR;
  assign unused_dc = ^word[WORD_W-1:USED_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      main_div   <= MAIN_FLOOR;
      test_bits  <= '0;
      ref_div    <= REF_FLOOR;
      pd_pol     <= 1'b0;
      unlock_thr <= 1'b0;
      unlock_ext <= '0;
      band_n     <= '1;
      clamp_flag <= 1'b0;
    end else if (load) begin
      if (word[SEL_BIT]) begin
        main_div   <= main_lo ? MAIN_FLOOR : main_raw;
        test_bits  <= word[TEST_LSB +: TEST_W];
        clamp_flag <= main_lo;
      end else begin
        ref_div    <= ref_lo ? REF_FLOOR : ref_raw;
        pd_pol     <= word[POL_BIT];
        unlock_thr <= word[THR_BIT];
        unlock_ext <= word[EXT_LSB +: EXT_W];
        band_n     <= ~word[PORT_LSB +: BAND_N];
        clamp_flag <= ref_lo;
      end
    end
  end

  p_main_floor_r8: assert property (@(posedge clk) disable iff (rst)
    main_div >= MAIN_FLOOR);
  p_ref_floor_r8: assert property (@(posedge clk) disable iff (rst)
    ref_div >= REF_FLOOR);
  p_main_keeps_ref_r4: assert property (@(posedge clk) disable iff (rst)
    (load && word[SEL_BIT]) |=> $stable(ref_div) && $stable(band_n) && $stable(pd_pol));
  p_ref_keeps_main_r4: assert property (@(posedge clk) disable iff (rst)
    (load && !word[SEL_BIT]) |=> $stable(main_div) && $stable(test_bits));
endmodule

// File: rtl/synth_ctl_if.sv
module synth_ctl_if import synth_ctl_pkg::*; #(
  parameter logic [DEVA_W-1:0] DEV_ADDR = 6'b110001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              i2c_rst_n,
  input  logic              sclk_i,
  input  logic              sdat_i,
  input  logic              ce_i,
  output logic              sdat_oe,
  output logic [MAIN_W-1:0] main_div,
  output logic [TEST_W-1:0] test_bits,
  output logic [REF_W-1:0]  ref_div,
  output logic              pd_pol,
  output logic              unlock_thr,
  output logic [EXT_W-1:0]  unlock_ext,
  output logic [BAND_N-1:0] band_n,
  output logic              clamp_flag
);
  logic [4:0]        pins_s;
  logic              sel_s, irst_n_s, sclk_s, sdat_s, ce_s;
  logic              tw_v, i2c_v, load;
  logic [WORD_W-1:0] tw_word, i2c_word, word;

  synth_pin_sync #(.W(5)) u_sync (
    .clk(clk), .rst(rst),
    .d({bus_sel, i2c_rst_n, sclk_i, sdat_i, ce_i}),
    .q(pins_s)
  );
  assign {sel_s, irst_n_s, sclk_s, sdat_s, ce_s} = pins_s;

  synth_tw_rx u_tw (
    .clk(clk), .rst(rst), .en(!sel_s),
    .sclk(sclk_s), .sdat(sdat_s), .cen(ce_s),
    .word_v(tw_v), .word(tw_word)
  );

  synth_i2c_wr #(.DEV_ADDR(DEV_ADDR)) u_i2c (
    .clk(clk), .rst(rst), .en(sel_s && irst_n_s),
    .scl(sclk_s), .sda(sdat_s), .ce(ce_s),
    .sda_oe(sdat_oe), .word_v(i2c_v), .word(i2c_word)
  );

  assign load = tw_v || i2c_v;
  assign word = i2c_v ? i2c_word : tw_word;

  synth_ctl_regs u_regs (
    .clk(clk), .rst(rst), .load(load), .word(word),
    .main_div(main_div), .test_bits(test_bits), .ref_div(ref_div),
    .pd_pol(pd_pol), .unlock_thr(unlock_thr), .unlock_ext(unlock_ext),
    .band_n(band_n), .clamp_flag(clamp_flag)
  );

  p_one_source_r1: assert property (@(posedge clk) disable iff (rst)
    !(tw_v && i2c_v));
endmodule

// File: tb/synth_ctl_if_tb_top.sv
`timescale 1ns/1ps
module synth_ctl_if_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, bus_sel = 1'b0, i2c_rst_n = 1'b1;
  logic sclk = 1'b1, sda_drv = 1'b1, ce = 1'b1;
  logic sdat_oe, pd_pol, unlock_thr, clamp_flag;
  logic [16:0] main_div;
  logic [1:0]  test_bits, unlock_ext;
  logic [11:0] ref_div;
  logic [2:0]  band_n;
  logic sdat_line;
  assign sdat_line = sda_drv & ~sdat_oe;

  synth_ctl_if dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .i2c_rst_n(i2c_rst_n),
    .sclk_i(sclk), .sdat_i(sdat_line), .ce_i(ce), .sdat_oe(sdat_oe),
    .main_div(main_div), .test_bits(test_bits), .ref_div(ref_div),
    .pd_pol(pd_pol), .unlock_thr(unlock_thr), .unlock_ext(unlock_ext),
    .band_n(band_n), .clamp_flag(clamp_flag)
  );

  typedef struct packed {
    logic [16:0] m; logic [1:0] ts; logic [11:0] r;
    logic pol; logic thr; logic [1:0] ext; logic [2:0] bn; logic flag;
  } snap_t;

  snap_t model, exp_q[$];
  string tag_q[$];
  int checks = 0, fails = 0;
  bit done = 1'b0;
  localparam int T = 30;
  localparam int Q = 10;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [23:0] mk_main(input logic [16:0] p, input logic [1:0] ts);
    return {4'hF, 1'b0, 1'b1, ts, p, 1'b1};
  endfunction

  function automatic logic [23:0] mk_ref(input logic [11:0] r, input logic pol, input logic thr,
                                         input logic [1:0] ext, input logic [2:0] port);
    return {4'hA, port, ext, thr, pol, r, 1'b0};
  endfunction

  function automatic void apply(input logic [23:0] w);
    if (w[0]) begin
      model.flag = (w[17:1] < 17'd4032);
      model.m    = model.flag ? 17'd4032 : w[17:1];
      model.ts   = w[19:18];
    end else begin
      model.flag = (w[12:1] < 12'd20);
      model.r    = model.flag ? 12'd20 : w[12:1];
      model.pol  = w[13];
      model.thr  = w[14];
      model.ext  = w[16:15];
      model.bn   = ~w[19:17];
    end
  endfunction

  task automatic expect_now(input string tag);
    exp_q.push_back(model);
    tag_q.push_back(tag);
    tick(16);
  endtask

  // Scoreboard monitor
  initial begin
    forever begin
      snap_t got, ex;
      string tg;
      wait (exp_q.size() > 0);
      tick(10);
      ex = exp_q.pop_front();
      tg = tag_q.pop_front();
      got = '{main_div, test_bits, ref_div, pd_pol, unlock_thr, unlock_ext, band_n, clamp_flag};
      checks++;
      if (got !== ex) begin
        fails++;
        $display("FAIL %s got=%h exp=%h", tg, got, ex);
      end
    end
  end

  task automatic tw_send(input logic [23:0] w, input int nbits);
    ce = 1'b0; tick(T);
    sclk = 1'b0; tick(T);
    for (int i = nbits - 1; i >= 0; i--) begin
      sda_drv = (i < 24) ? w[i] : 1'b0;
      tick(T); sclk = 1'b1; tick(T); sclk = 1'b0;
    end
    tick(T); ce = 1'b1; tick(T);
    sda_drv = 1'b1; tick(T); sclk = 1'b1; tick(T);
  endtask

  task automatic i2c_start();
    sda_drv = 1'b0; tick(Q); sclk = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    sda_drv = 1'b0; tick(Q); sclk = 1'b1; tick(Q); sda_drv = 1'b1; tick(Q);
  endtask

  task automatic i2c_byte(input logic [7:0] b, input logic exp_ack, input string tag);
    logic got;
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; tick(Q); sclk = 1'b1; tick(2 * Q); sclk = 1'b0; tick(Q);
    end
    sda_drv = 1'b1; tick(Q); sclk = 1'b1; tick(Q);
    got = ~sdat_line;
    tick(Q); sclk = 1'b0; tick(Q);
    checks++;
    if (got !== exp_ack) begin
      fails++;
      $display("FAIL %s ack got=%0b exp=%0b", tag, got, exp_ack);
    end
  endtask

  task automatic i2c_write(input logic [7:0] ab, input logic [23:0] w, input int nb,
                           input logic aok, input string tag);
    i2c_start();
    i2c_byte(ab, aok, tag);
    for (int k = 0; k < nb; k++)
      i2c_byte((k < 3) ? w[23 - 8 * k -: 8] : 8'hA5, aok && (k < 3), tag);
    i2c_stop();
  endtask

  initial begin
    model = '{17'd4032, 2'd0, 12'd20, 1'b0, 1'b0, 2'd0, 3'b111, 1'b0};
    tick(6); rst = 1'b0; tick(6);
    expect_now("R9 reset state");

    // 3-wire mode
    tw_send(mk_main(17'd100000, 2'b10), 24); apply(mk_main(17'd100000, 2'b10));
    expect_now("R2 R3 R4 3-wire main write");
    tw_send(mk_ref(12'd2048, 1'b1, 1'b0, 2'b01, 3'b101), 24);
    apply(mk_ref(12'd2048, 1'b1, 1'b0, 2'b01, 3'b101));
    expect_now("R4 R7 3-wire ref write");
    tw_send(mk_ref(12'd300, 1'b0, 1'b1, 2'b10, 3'b010), 24);
    apply(mk_ref(12'd300, 1'b0, 1'b1, 2'b10, 3'b010));
    expect_now("R7 R2 ref write second pattern");
    tw_send(mk_main(17'd5000, 2'b01), 23);
    expect_now("R3 23-bit frame discarded");
    tw_send(mk_main(17'd6000, 2'b01), 25);
    expect_now("R3 25-bit frame discarded");
    tw_send(mk_main(17'd4031, 2'b00), 24); apply(mk_main(17'd4031, 2'b00));
    expect_now("R8 main 4031 clamped");
    tw_send(mk_main(17'd4032, 2'b00), 24); apply(mk_main(17'd4032, 2'b00));
    expect_now("R8 main 4032 unclamped");
    tw_send(mk_main(17'd0, 2'b11), 24); apply(mk_main(17'd0, 2'b11));
    expect_now("R8 main 0 clamped");
    tw_send(mk_ref(12'd19, 1'b1, 1'b1, 2'b11, 3'b000), 24);
    apply(mk_ref(12'd19, 1'b1, 1'b1, 2'b11, 3'b000));
    expect_now("R8 ref 19 clamped");
    tw_send(mk_ref(12'd20, 1'b0, 1'b0, 2'b00, 3'b111), 24);
    apply(mk_ref(12'd20, 1'b0, 1'b0, 2'b00, 3'b111));
    expect_now("R8 ref 20 unclamped");
    i2c_write({6'b110001, 1'b1, 1'b0}, mk_main(17'd9999, 2'b00), 3, 1'b0, "R1 i2c in 3-wire mode");
    expect_now("R1 i2c ignored in 3-wire mode");

    // I2C mode
    bus_sel = 1'b1; tick(10);
    tw_send(mk_main(17'd7777, 2'b00), 24);
    expect_now("R1 3-wire ignored in i2c mode");
    ce = 1'b1;
    i2c_write({6'b110001, 1'b1, 1'b0}, mk_main(17'd131071, 2'b01), 3, 1'b1, "R5 R6 main write");
    apply(mk_main(17'd131071, 2'b01));
    expect_now("R6 i2c main write applied");
    ce = 1'b0; tick(10);
    i2c_write({6'b110001, 1'b0, 1'b0}, mk_ref(12'd4095, 1'b1, 1'b0, 2'b10, 3'b011), 3, 1'b1, "R5 ce low");
    apply(mk_ref(12'd4095, 1'b1, 1'b0, 2'b10, 3'b011));
    expect_now("R5 i2c ref write with ce low");
    i2c_write({6'b110001, 1'b1, 1'b0}, mk_main(17'd8000, 2'b00), 3, 1'b0, "R5 ce bit mismatch");
    expect_now("R5 mismatched ce bit ignored");
    i2c_write({6'b110001, 1'b0, 1'b1}, mk_main(17'd8000, 2'b00), 3, 1'b0, "R5 read bit");
    expect_now("R5 read request ignored");
    i2c_write({6'b110011, 1'b0, 1'b0}, mk_main(17'd8000, 2'b00), 3, 1'b0, "R5 wrong device");
    expect_now("R5 wrong device address ignored");
    i2c_write({6'b110001, 1'b0, 1'b0}, mk_main(17'd8000, 2'b00), 2, 1'b1, "R6 short");
    expect_now("R6 two-byte transfer discarded");
    i2c_write({6'b110001, 1'b0, 1'b0}, mk_main(17'd8000, 2'b00), 4, 1'b1, "R6 long");
    expect_now("R6 four-byte transfer discarded");
    i2c_write({6'b110001, 1'b0, 1'b0}, mk_main(17'd10, 2'b10), 3, 1'b1, "R8 i2c clamp");
    apply(mk_main(17'd10, 2'b10));
    expect_now("R8 i2c main clamped");
    // slave reset mid-transfer
    i2c_start();
    i2c_byte({6'b110001, 1'b0, 1'b0}, 1'b1, "R9 addr before slave reset");
    i2c_byte(8'h01, 1'b1, "R9 byte before slave reset");
    tick(Q); i2c_rst_n = 1'b0; tick(10); i2c_rst_n = 1'b1; tick(10);
    i2c_byte(8'h40, 1'b0, "R9 byte after slave reset");
    i2c_byte(8'h01, 1'b0, "R9 byte after slave reset");
    i2c_stop();
    expect_now("R9 slave reset drops partial transfer");

    wait (exp_q.size() == 0);
    tick(12);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule